// File: doc/BRIEF.md
# Clock-Synthesizer Indexed Register File

This block models the register bank of the programmable clock synthesizer inside a video palette converter, seen from the host as a byte-wide bus target. Four port addresses are decoded: a pixel-mask port, a read-index port, a write-index port and a data port. A register-select input, `rs_pll`, moves the mask port and the data port between palette mode and synthesizer mode. The index ports reach the same two index registers in both modes.

In synthesizer mode the data port walks a table of sixteen clock entries. Each entry is a pair of bytes, a multiplier byte M and a divider byte N (N1 in bits 4:0, post-divider N2 in bits 6:5). Both bytes pass through the single data port under an internal byte toggle, so the index moves on only after the N byte. Entries 0 and 1 are fixed constants. Entry 2 is the programmable pixel clock and entry 10 holds the memory clock. Index 14 is a lone control byte and not a pair. The mask port reaches the command byte, which selects the pixel format.

A hidden identification sequence works in either mode. A read of the write-index port arms it. The three mask-port reads that follow return their normal data, and the fourth returns the identification byte. Software uses this to detect the part, and it saves and restores state through the readable index ports.

Top module: `clksyn_regfile`

## Requirements
- R1: After reset both indices read 0, both byte toggles point at the M byte, the command byte reads 0x00, the pixel mask reads 0xFF, the control byte (index 14) reads 0x20 and entry 2 reads M=0x21, N=0x42.
- R2: Entry 0 always reads M=0x28, N=0x61 and entry 1 always reads M=0x3D, N=0x62. Data writes aimed at them change nothing, but they still step the write index.
- R3: In synthesizer mode (`rs_pll`=1) each data access to a pair entry first reaches M and then N. The index steps by one after the N byte and wraps from 15 to 0. From read index 0, eight reads give f0.M, f0.N, f1.M, f1.N, f2.M, f2.N, f3.M, f3.N.
- R4: A write to either index port returns both byte toggles to the M byte.
- R5: Index 14 is a single control byte. One data access reads or writes all 8 bits and then steps the index by one, and the toggle stays on M.
- R6: Bit 7 of every M and N byte reads as 0, and a written bit 7 is discarded.
- R7: The mask port (bus_sel 0) reads and writes the command byte when `rs_pll`=1 and the pixel-mask byte when `rs_pll`=0. The two bytes are independent.
- R8: With `rs_pll`=0 a data-port (bus_sel 3) read returns 0x00, and a data-port write changes no entry and no index.
- R9: After a read of the write-index port (bus_sel 2), three mask-port reads return normal data and the fourth returns 0x71 (upper nibble 0x7). Any other access between them cancels the sequence.
- R10: The read index (bus_sel 1) and the write index (bus_sel 2) read back their current values, zero-extended to 8 bits.
- R11: Read data appears on `rdata` with `rd_valid` high in the cycle after the read strobe. `rdata` holds its value while no read is strobed.
- R12: Entry 10 (memory clock) resets to M=0x3B, N=0x41 and is writable like any other pair entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rs_pll | input | 1 | Register select: 1 = synthesizer mode, 0 = palette mode |
| bus_sel | input | 2 | Port address: 0 mask/command, 1 read index, 2 write index, 3 data |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rd_valid | output | 1 | High in the cycle that rdata carries a new read result |

## Verification
The assertions assume the host never strobes a read and a write in the same cycle, and one of them checks this at the ports. They also assume `bus_sel` and `rs_pll` stay steady for the whole strobe cycle. The bench drives each access as a single strobe cycle on the falling edge, follows it with one idle cycle, and changes select lines only while no strobe is active. Expected bytes come from arithmetic patterns indexed by entry number, masked to seven bits, with the fixed entries and the control slot handled separately.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;
  typedef enum logic [1:0] {
    PORT_MASK = 2'd0,
    PORT_RIDX = 2'd1,
    PORT_WIDX = 2'd2,
    PORT_DATA = 2'd3
  } port_e;

  // Fixed synthesizer entries (read-only)
  localparam logic [7:0] FIX0_M = 8'h28;
  localparam logic [7:0] FIX0_N = 8'h61;
  localparam logic [7:0] FIX1_M = 8'h3D;
  localparam logic [7:0] FIX1_N = 8'h62;
  localparam int         FIX_CNT = 2;
  localparam int         PIX_IDX = 2;
endpackage

// File: rtl/clksyn_idx_seq.sv
module clksyn_idx_seq #(
  parameter int IDX_W    = 4,
  parameter int CTRL_IDX = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             clr_half,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             half
);
  localparam logic [IDX_W-1:0] CTRL_I = IDX_W'(CTRL_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx  <= '0;
      half <= 1'b0;
    end else if (load) begin
      idx  <= load_val;
      half <= 1'b0;
    end else if (clr_half) begin
      half <= 1'b0;
    end else if (step) begin
      if (idx == CTRL_I || half) begin
        idx  <= idx + 1'b1;
        half <= 1'b0;
      end else begin
        half <= 1'b1;
      end
    end
  end

  p_pair_adv_r3: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !clr_half && half && idx != CTRL_I)
      |=> (idx == $past(idx) + 1'b1) && !half);

  p_m_first_r3: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !clr_half && !half && idx != CTRL_I)
      |=> $stable(idx) && half);

  p_ctrl_single_r5: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !clr_half && idx == CTRL_I)
      |=> (idx == $past(idx) + 1'b1) && !half);

  p_toggle_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (load || clr_half) |=> !half);
endmodule

// File: rtl/clksyn_pair_store.sv
module clksyn_pair_store
  import clksyn_pkg::*;
#(
  parameter int         IDX_W    = 4,
  parameter int         CTRL_IDX = 14,
  parameter int         MCLK_IDX = 10,
  parameter logic [7:0] PIX_M_RST  = 8'h21,
  parameter logic [7:0] PIX_N_RST  = 8'h42,
  parameter logic [7:0] MCLK_M_RST = 8'h3B,
  parameter logic [7:0] MCLK_N_RST = 8'h41,
  parameter logic [7:0] CTRL_RST   = 8'h20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic             whalf,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] ridx,
  input  logic             rhalf,
  output logic [7:0]       rbyte
);
  localparam int NUM_ENT = 1 << IDX_W;
  localparam logic [IDX_W-1:0] CTRL_I = IDX_W'(CTRL_IDX);
  localparam logic [IDX_W-1:0] FIX_LIM = IDX_W'(FIX_CNT);

  logic [6:0] m_mem [NUM_ENT];
  logic [6:0] n_mem [NUM_ENT];
  logic [7:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (i == PIX_IDX) begin
          m_mem[i] <= PIX_M_RST[6:0];
          n_mem[i] <= PIX_N_RST[6:0];
        end else if (i == MCLK_IDX) begin
          m_mem[i] <= MCLK_M_RST[6:0];
          n_mem[i] <= MCLK_N_RST[6:0];
        end else begin
          m_mem[i] <= '0;
          n_mem[i] <= '0;
        end
      end
      ctrl_q <= CTRL_RST;
    end else if (we) begin
      if (widx == CTRL_I) begin
        ctrl_q <= wdata;
      end else if (widx >= FIX_LIM) begin
        if (whalf) n_mem[widx] <= wdata[6:0];
        else       m_mem[widx] <= wdata[6:0];
      end
    end
  end

  always_comb begin
    if (ridx == CTRL_I)
      rbyte = ctrl_q;
    else if (ridx == IDX_W'(0))
      rbyte = rhalf ? FIX0_N : FIX0_M;
    else if (ridx == IDX_W'(1))
      rbyte = rhalf ? FIX1_N : FIX1_M;
    else
      rbyte = {1'b0, rhalf ? n_mem[ridx] : m_mem[ridx]};
  end

  p_ctrl_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (!we || widx != CTRL_I) |=> $stable(ctrl_q));
endmodule

// File: rtl/clksyn_id_seq.sv
module clksyn_id_seq #(
  parameter int ID_POS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic track,
  input  logic other,
  output logic fire
);
  localparam int CW = $clog2(ID_POS + 1);
  localparam logic [CW-1:0] LAST = CW'(ID_POS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (arm) begin
      cnt <= CW'(1);
    end else if (other) begin
      cnt <= '0;
    end else if (track && cnt != '0) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign fire = (cnt == LAST);

  p_fire_once_r9: assert property (@(posedge clk) disable iff (rst)
    (fire && track && !arm) |=> !fire);

  p_cancel_r9: assert property (@(posedge clk) disable iff (rst)
    (other && !arm) |=> !fire);
endmodule

// File: rtl/clksyn_regfile.sv
module clksyn_regfile
  import clksyn_pkg::*;
#(
  parameter int         IDX_W    = 4,
  parameter int         CTRL_IDX = 14,
  parameter int         MCLK_IDX = 10,
  parameter int         ID_POS   = 4,
  parameter logic [7:0] CHIP_ID  = 8'h71,
  parameter logic [7:0] CMD_RST  = 8'h00,
  parameter logic [7:0] MASK_RST = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rs_pll,
  input  logic [1:0] bus_sel,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rd_valid
);
  localparam logic [IDX_W-1:0] CTRL_I = IDX_W'(CTRL_IDX);

  port_e port;
  assign port = port_e'(bus_sel);

  logic ridx_wr, widx_wr, pll_rd, pll_wr;
  logic id_arm, id_track, id_other, id_fire;
  logic [IDX_W-1:0] r_idx, w_idx;
  logic r_half, w_half;
  logic [7:0] store_byte, mask_q, cmd_q, rd_next;

  assign ridx_wr = wr_en && port == PORT_RIDX;
  assign widx_wr = wr_en && port == PORT_WIDX;
  assign pll_rd  = rd_en && port == PORT_DATA && rs_pll;
  assign pll_wr  = wr_en && port == PORT_DATA && rs_pll;

  clksyn_idx_seq #(.IDX_W(IDX_W), .CTRL_IDX(CTRL_IDX)) u_rd_idx (
    .clk(clk), .rst(rst), .load(ridx_wr), .load_val(wdata[IDX_W-1:0]),
    .clr_half(widx_wr), .step(pll_rd), .idx(r_idx), .half(r_half)
  );

  clksyn_idx_seq #(.IDX_W(IDX_W), .CTRL_IDX(CTRL_IDX)) u_wr_idx (
    .clk(clk), .rst(rst), .load(widx_wr), .load_val(wdata[IDX_W-1:0]),
    .clr_half(ridx_wr), .step(pll_wr), .idx(w_idx), .half(w_half)
  );

  clksyn_pair_store #(.IDX_W(IDX_W), .CTRL_IDX(CTRL_IDX), .MCLK_IDX(MCLK_IDX)) u_store (
    .clk(clk), .rst(rst), .we(pll_wr), .widx(w_idx), .whalf(w_half),
    .wdata(wdata), .ridx(r_idx), .rhalf(r_half), .rbyte(store_byte)
  );

  assign id_arm   = rd_en && port == PORT_WIDX;
  assign id_track = rd_en && port == PORT_MASK;
  assign id_other = (rd_en || wr_en) && !id_arm && !id_track;

  clksyn_id_seq #(.ID_POS(ID_POS)) u_id (
    .clk(clk), .rst(rst), .arm(id_arm), .track(id_track),
    .other(id_other), .fire(id_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= MASK_RST;
      cmd_q  <= CMD_RST;
    end else if (wr_en && port == PORT_MASK) begin
      if (rs_pll) cmd_q  <= wdata;
      else        mask_q <= wdata;
    end
  end

  always_comb begin
    unique case (port)
      PORT_MASK: rd_next = id_fire ? CHIP_ID : (rs_pll ? cmd_q : mask_q);
      PORT_RIDX: rd_next = {{(8-IDX_W){1'b0}}, r_idx};
      PORT_WIDX: rd_next = {{(8-IDX_W){1'b0}}, w_idx};
      default:   rd_next = rs_pll ? store_byte : 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_next;
    end
  end

  p_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en));

  p_valid_r11: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata) && !rd_valid);

  p_bit7_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && port == PORT_DATA && rs_pll && r_idx != CTRL_I) |=> !rdata[7]);

  p_id_r9: assert property (@(posedge clk) disable iff (rst)
    (id_track && id_fire) |=> rdata == CHIP_ID);

  p_pal_data_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && port == PORT_DATA && !rs_pll) |=> rdata == 8'h00);
endmodule

// File: tb/test_clksyn_regfile.sv
module test_clksyn_regfile;
  localparam int CLK_T = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rs_pll = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rd_valid;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_T/2) clk = ~clk;

  clksyn_regfile i_clksyn_regfile (
    .clk(clk), .rst(rst), .rs_pll(rs_pll), .bus_sel(bus_sel),
    .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .rd_valid(rd_valid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] s, input logic rs, input logic [7:0] d);
    @(negedge clk);
    bus_sel = s; rs_pll = rs; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] s, input logic rs, output logic [7:0] d);
    @(negedge clk);
    bus_sel = s; rs_pll = rs; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  function automatic logic [7:0] pat_m(input int i);
    return 8'((i * 37 + 133) & 255);
  endfunction
  function automatic logic [7:0] pat_n(input int i);
    return 8'((i * 53 + 200) & 255);
  endfunction

  initial begin
    #(CLK_T * 150000);
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d, held;
    logic [7:0] exp_seq [8];
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    bus_rd(2'd0, 1'b1, d); chk("R1 cmd reset", d, 8'h00);
    bus_rd(2'd0, 1'b0, d); chk("R1 mask reset", d, 8'hFF);
    bus_rd(2'd1, 1'b1, d); chk("R1 ridx reset", d, 0);
    bus_rd(2'd2, 1'b1, d); chk("R1 widx reset", d, 0);

    // R3: eight reads from index 0
    exp_seq = '{8'h28, 8'h61, 8'h3D, 8'h62, 8'h21, 8'h42, 8'h00, 8'h00};
    for (int k = 0; k < 8; k++) begin
      bus_rd(2'd3, 1'b1, d); chk("R3 R1 R2 reset sequence", d, exp_seq[k]);
    end
    bus_rd(2'd1, 1'b1, d); chk("R3 R10 ridx after four pairs", d, 4);

    // R11: valid timing and hold
    chk("R11 rd_valid after read", rd_valid, 1);
    held = rdata;
    @(negedge clk);
    chk("R11 rd_valid idle", rd_valid, 0);
    chk("R11 rdata held", rdata, held);

    // R12: memory clock defaults
    bus_wr(2'd1, 1'b1, 8'd10);
    bus_rd(2'd3, 1'b1, d); chk("R12 mclk M", d, 8'h3B);
    bus_rd(2'd3, 1'b1, d); chk("R12 mclk N", d, 8'h41);

    // R5: control byte default, single access
    bus_wr(2'd1, 1'b1, 8'd14);
    bus_rd(2'd3, 1'b1, d); chk("R5 R1 ctrl reset", d, 8'h20);
    bus_rd(2'd1, 1'b1, d); chk("R5 ridx after ctrl", d, 15);

    // Full write sweep from index 2, wrapping through fixed entries
    bus_wr(2'd2, 1'b1, 8'd2);
    for (int i = 2; i < 16; i++) begin
      if (i == 14) bus_wr(2'd3, 1'b1, 8'hA5);
      else begin
        bus_wr(2'd3, 1'b1, pat_m(i));
        bus_wr(2'd3, 1'b1, pat_n(i));
      end
    end
    for (int k = 0; k < 4; k++) bus_wr(2'd3, 1'b1, 8'hFF);
    bus_rd(2'd2, 1'b1, d); chk("R3 R2 widx wrapped", d, 2);

    // Full read sweep from index 0
    bus_wr(2'd1, 1'b1, 8'd0);
    for (int i = 0; i < 16; i++) begin
      if (i == 0) begin
        bus_rd(2'd3, 1'b1, d); chk("R2 f0 M", d, 8'h28);
        bus_rd(2'd3, 1'b1, d); chk("R2 f0 N", d, 8'h61);
      end else if (i == 1) begin
        bus_rd(2'd3, 1'b1, d); chk("R2 f1 M", d, 8'h3D);
        bus_rd(2'd3, 1'b1, d); chk("R2 f1 N", d, 8'h62);
      end else if (i == 14) begin
        bus_rd(2'd3, 1'b1, d); chk("R5 ctrl full byte", d, 8'hA5);
      end else begin
        bus_rd(2'd3, 1'b1, d); chk("R6 R3 M sweep", d, pat_m(i) & 8'h7F);
        bus_rd(2'd3, 1'b1, d); chk("R6 R3 N sweep", d, pat_n(i) & 8'h7F);
      end
    end
    bus_rd(2'd1, 1'b1, d); chk("R3 R10 ridx wrapped", d, 0);

    // R4: index writes reset toggles
    bus_wr(2'd1, 1'b1, 8'd3);
    bus_rd(2'd3, 1'b1, d); chk("R4 first M", d, pat_m(3) & 8'h7F);
    bus_wr(2'd2, 1'b1, 8'd4);
    bus_rd(2'd3, 1'b1, d); chk("R4 M again after widx write", d, pat_m(3) & 8'h7F);
    bus_wr(2'd3, 1'b1, 8'h11);
    bus_wr(2'd2, 1'b1, 8'd4);
    bus_wr(2'd3, 1'b1, 8'h22);
    bus_wr(2'd3, 1'b1, 8'h33);
    bus_wr(2'd1, 1'b1, 8'd4);
    bus_rd(2'd3, 1'b1, d); chk("R4 M rewritten", d, 8'h22);
    bus_rd(2'd3, 1'b1, d); chk("R4 N after M", d, 8'h33);

    // R8: palette-mode data port
    bus_wr(2'd3, 1'b0, 8'h7E);
    bus_rd(2'd3, 1'b0, d); chk("R8 palette data read", d, 8'h00);
    bus_rd(2'd2, 1'b1, d); chk("R8 R10 widx unmoved", d, 5);
    bus_rd(2'd1, 1'b1, d); chk("R8 ridx unmoved", d, 5);
    bus_rd(2'd3, 1'b1, d); chk("R8 entry5 intact", d, pat_m(5) & 8'h7F);

    // R7: mask vs command
    bus_wr(2'd0, 1'b0, 8'h5A);
    bus_wr(2'd0, 1'b1, 8'h50);
    bus_rd(2'd0, 1'b0, d); chk("R7 mask", d, 8'h5A);
    bus_rd(2'd0, 1'b1, d); chk("R7 cmd", d, 8'h50);

    // R9: identification sequence in synthesizer mode
    bus_rd(2'd2, 1'b1, d);
    for (int k = 0; k < 3; k++) begin
      bus_rd(2'd0, 1'b1, d); chk("R9 normal before id", d, 8'h50);
    end
    bus_rd(2'd0, 1'b1, d); chk("R9 id read", d, 8'h71);
    bus_rd(2'd0, 1'b1, d); chk("R9 after id", d, 8'h50);

    // R9: cancel by intervening access
    bus_rd(2'd2, 1'b1, d);
    bus_rd(2'd0, 1'b1, d);
    bus_rd(2'd0, 1'b1, d);
    bus_rd(2'd1, 1'b1, d);
    bus_rd(2'd0, 1'b1, d); chk("R9 cancelled 3rd", d, 8'h50);
    bus_rd(2'd0, 1'b1, d); chk("R9 cancelled 4th", d, 8'h50);

    // R9: identification in palette mode
    bus_rd(2'd2, 1'b0, d);
    for (int k = 0; k < 3; k++) begin
      bus_rd(2'd0, 1'b0, d); chk("R9 palette normal", d, 8'h5A);
    end
    bus_rd(2'd0, 1'b0, d); chk("R9 palette id", d, 8'h71);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule